// File: doc/BRIEF.md
# Two-Edge Reciprocal Period Capture

The block measures one period of an input signal in base-clock counts. A free-running counter advances on every base clock. When the block is armed, the first qualified rising edge of the input latches the counter as the start value and the second latches it as the stop value. The block then disarms itself and raises done. The difference between the two values is the period, corrected for counter wrap. The result and done stay put until the next arm.

The input is asynchronous. It passes through a two-stage synchronizer and is then sampled once every four base clocks. The filtered level changes only after eight samples in a row disagree with it, so runt pulses and chatter never reach the edge detector. Only rising transitions of the filtered level count. A controller arms the block, waits for done, reads the period, and arms it again for the next measurement.

Top module: `period_capture`

## Requirements
- R1: After reset, done_o is 0, period_o is 0, and the block is disarmed: rising edges before the first arm change neither output.
- R2: A one-cycle arm_i pulse puts the block in the wait-for-start step and clears done_o from the next cycle on. Arm wins over an edge qualified in the same cycle.
- R3: In the wait-for-start step, a qualified rising edge latches the counter as the start value and moves the block to the wait-for-stop step.
- R4: In the wait-for-stop step, the next qualified rising edge latches the counter as the stop value, disables capture, and sets done_o.
- R5: done_o is 1 only after the second capture. Further edges in that state leave done_o and period_o unchanged until the next arm.
- R6: period_o equals stop minus start when stop is not below start, and stop plus 2^CNT_W minus start otherwise. For an input whose rising edges are a multiple of four clocks apart, it equals that spacing exactly.
- R7: The input is sampled every 4 clocks after a 2-stage synchronizer. The filtered level flips only after 8 consecutive samples differ from it. A high pulse shorter than 8 sample periods is never seen as an edge.
- R8: Only low-to-high transitions of the filtered level are captured. A high-to-low transition neither starts nor stops a measurement.
- R9: The base counter is 0 after reset and increments by one, modulo 2^CNT_W, on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock; also the counting reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | One-cycle pulse that starts a new measurement |
| sig_i | input | 1 | Asynchronous signal whose period is measured |
| done_o | output | 1 | High once both edges have been captured |
| period_o | output | CNT_W | Stop minus start, wrap corrected |

## Verification
The hardest case to reach is a measurement in which the counter wraps between the start and stop captures. With a 32-bit counter that would take billions of cycles. The bench therefore builds the block with a 10-bit counter and repeats 200-cycle measurements whose start times drift against the 1024-cycle wrap, so several stop values land below their start values. Arming while the input is already high, and arming just before runt pulses, exercise the falling-edge and filter rules. A behavioural model tracks every clock.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_STOP  = 2'd2,
    ST_DONE  = 2'd3
  } cap_step_e;
endpackage

// File: rtl/pc_free_counter.sv
module pc_free_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/pc_sync_filter.sv
module pc_sync_filter #(
  parameter int SYNC     = 2,
  parameter int DIV      = 4,
  parameter int FILT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int RUN_W = $clog2(FILT_LEN);

  logic [SYNC-1:0]  sync_q;
  logic             synced;
  logic             sample_en;
  logic             filt_q;
  logic             edge_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-2:0], sig_i};
  end
  assign synced = sync_q[SYNC-1];

  generate
    if (DIV > 1) begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          div_q <= '0;
        else if (div_q == DIV_W'(DIV - 1))    div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign sample_en = (div_q == DIV_W'(DIV - 1));
    end else begin : g_nodiv
      assign sample_en = 1'b1;
    end
  endgenerate

  // level flips only after FILT_LEN disagreeing samples in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      run_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= 1'b0;
      if (sample_en) begin
        if (synced == filt_q) begin
          run_q <= '0;
        end else if (run_q == RUN_W'(FILT_LEN - 1)) begin
          filt_q <= synced;
          run_q  <= '0;
          edge_q <= synced;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign rise_o = edge_q;

  assert_filt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en |=> $stable(filt_q));
  assert_rise_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q |-> (filt_q && !$past(filt_q)));
endmodule

// File: rtl/pc_capture_fsm.sv
module pc_capture_fsm
  import pc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             done_o,
  output logic [CNT_W-1:0] period_o
);
  cap_step_e        step_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_IDLE;
      start_q <= '0;
      stop_q  <= '0;
    end else if (arm_i) begin
      step_q <= ST_START;
    end else if (rise_i) begin
      unique case (step_q)
        ST_START: begin start_q <= cnt_i; step_q <= ST_STOP; end
        ST_STOP:  begin stop_q  <= cnt_i; step_q <= ST_DONE; end
        default:  ;
      endcase
    end
  end

  assign done_o   = (step_q == ST_DONE);
  // modular subtract == adding 2^CNT_W when stop < start
  assign period_o = stop_q - start_q;

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_IDLE && !arm_i) |=> (step_q == ST_IDLE && $stable(start_q)));
  assert_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (step_q == ST_START && !done_o));
  assert_start_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_START && rise_i && !arm_i) |=>
      (step_q == ST_STOP && start_q == $past(cnt_i)));
  assert_stop_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_STOP && rise_i && !arm_i) |=>
      (done_o && stop_q == $past(cnt_i)));
  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> (done_o && $stable(period_o)));
endmodule

// File: rtl/period_capture.sv
module period_capture #(
  parameter int CNT_W    = 32,
  parameter int SYNC     = 2,
  parameter int DIV      = 4,
  parameter int FILT_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             sig_i,
  output logic             done_o,
  output logic [CNT_W-1:0] period_o
);
  logic             rise;
  logic [CNT_W-1:0] cnt;

  pc_sync_filter #(.SYNC(SYNC), .DIV(DIV), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_i),
    .rise_o(rise)
  );

  pc_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  pc_capture_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .rise_i  (rise),
    .cnt_i   (cnt),
    .done_o  (done_o),
    .period_o(period_o)
  );

  assert_period_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> done_o && period_o == $past(period_o));
endmodule

// File: tb/sim_period_capture.sv
module sim_period_capture;
  localparam int W   = 10;
  localparam int MOD = 1 << W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic arm_i = 1'b0;
  logic sig_i = 1'b0;
  logic done_o;
  logic [W-1:0] period_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  period_capture #(.CNT_W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .sig_i(sig_i),
    .done_o(done_o), .period_o(period_o)
  );

  // behavioural reference
  int m_s1, m_s2, m_ph, m_run, m_filt, m_edge, m_cnt, m_st, m_start, m_stop;

  always @(posedge clk_i) begin
    int n_s1, n_s2, n_ph, n_run, n_filt, n_edge, n_cnt;
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_ph = 0; m_run = 0; m_filt = 0; m_edge = 0;
      m_cnt = 0; m_st = 0; m_start = 0; m_stop = 0;
    end else begin
      n_s1 = int'(sig_i); n_s2 = m_s1;
      n_ph = (m_ph + 1) % 4;
      n_run = m_run; n_filt = m_filt; n_edge = 0;
      if (m_ph == 3) begin
        if (m_s2 == m_filt) n_run = 0;
        else if (m_run == 7) begin n_filt = m_s2; n_run = 0; n_edge = m_s2; end
        else n_run = m_run + 1;
      end
      n_cnt = (m_cnt + 1) % MOD;
      if (arm_i) m_st = 1;
      else if (m_edge == 1) begin
        if (m_st == 1) begin m_start = m_cnt; m_st = 2; end
        else if (m_st == 2) begin m_stop = m_cnt; m_st = 3; end
      end
      m_s1 = n_s1; m_s2 = n_s2; m_ph = n_ph; m_run = n_run;
      m_filt = n_filt; m_edge = n_edge; m_cnt = n_cnt;
    end
  end

  function automatic int exp_period();
    if (m_stop >= m_start) return m_stop - m_start;
    return m_stop + MOD - m_start;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      n_cmp++;
      if (done_o !== (m_st == 3)) begin
        n_bad++;
        $display("FAIL R5 model done: actual %0b expected %0b at %0t", done_o, m_st == 3, $time);
      end
      n_cmp++;
      if (int'(period_o) != exp_period()) begin
        n_bad++;
        $display("FAIL R6 model period: actual %0d expected %0d at %0t", period_o, exp_period(), $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic arm();
    arm_i = 1'b1;
    cyc(1);
    arm_i = 1'b0;
  endtask

  task automatic train(input int hi, input int lo, input int n);
    repeat (n) begin
      sig_i = 1'b1; cyc(hi);
      sig_i = 1'b0; cyc(lo);
    end
  endtask

  initial begin
    cyc(5);
    rst_ni = 1'b1;
    cyc(1);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset period", int'(period_o), 0);
    check("R9 first count period", int'(period_o), 0);

    train(48, 52, 2);
    check("R1 unarmed edges done", int'(done_o), 0);
    check("R1 unarmed edges period", int'(period_o), 0);

    arm();
    check("R2 after arm", int'(done_o), 0);
    train(48, 52, 4);
    check("R4 done after two edges", int'(done_o), 1);
    check("R3 R6 R9 period 100", int'(period_o), 100);

    train(60, 60, 2);
    check("R5 done held", int'(done_o), 1);
    check("R5 period held", int'(period_o), 100);

    arm();
    check("R2 done cleared", int'(done_o), 0);
    train(20, 40, 5);
    check("R7 runt pulses ignored", int'(done_o), 0);
    train(64, 56, 3);
    check("R7 real edges after runts done", int'(done_o), 1);
    check("R7 R3 period 120", int'(period_o), 120);

    sig_i = 1'b1; cyc(60);
    arm();
    sig_i = 1'b1; cyc(20);
    train(68, 68, 3);
    sig_i = 1'b0; cyc(10);
    check("R8 falling ignored done", int'(done_o), 1);
    check("R8 rising to rising 136", int'(period_o), 136);

    for (int k = 0; k < 8; k++) begin
      arm();
      cyc(13 * k);
      train(100, 100, 3);
      check($sformatf("R6 wrap run %0d", k), int'(period_o), 200);
      check($sformatf("R4 wrap done %0d", k), int'(done_o), 1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule